// File: doc/BRIEF.md
# Byte-Lane Word Access Sequencer

This block turns single processor-side memory requests into cycles on a 16-bit memory bus that is split into two 8-bit lanes. A request names a 20-bit byte address, a size (byte or 16-bit word), a direction and, for writes, the data. The block works out how many bus cycles the access needs, puts each byte on the lane its address selects, and drives one enable per lane. For reads it collects the returned bytes into a right-justified result. A one-cycle completion pulse ends every access.

Bytes at even addresses use lane 0 (bus bits 7:0), and bytes at odd addresses use lane 1 (bits 15:8). Words are little-endian: the low byte sits at the lower address. A word at an even address fills both lanes in one cycle. A word at an odd address straddles two bus words, so the block splits it into two single-lane cycles. The first goes to the odd address on lane 1 and carries the low byte. The second goes to the next address on lane 0 and carries the high byte. The block then reassembles the two bytes in order.

The bus side has no wait states: each bus cycle lasts exactly one clock, and read data is valid during the cycle in which it is addressed.

Top module: `byte_lane_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `bus_valid`, `bus_be` and `rsp_done` are 0.
- R2: A byte access at an even address makes one bus cycle at that address with `bus_be` = 2'b01, and write data appears on bus bits 7:0.
- R3: A byte access at an odd address makes one bus cycle at that address with `bus_be` = 2'b10, and write data appears on bus bits 15:8.
- R4: A word access at an even address makes one bus cycle with `bus_be` = 2'b11 and the whole word on the bus. A word read returns the bus word unchanged.
- R5: A word access at an odd address A makes exactly two back-to-back bus cycles. The first is at A with `bus_be` = 2'b10, with the low data byte on bits 15:8. The second is at A+1 with `bus_be` = 2'b01, with the high data byte on bits 7:0.
- R6: An odd-address word read returns {lane-0 byte of the second cycle, lane-1 byte of the first cycle} in `rsp_rdata`.
- R7: A byte read returns the byte of the lane used in `rsp_rdata[7:0]`, with bits 15:8 zero.
- R8: The address of the second cycle is A+1 modulo 2^20, so a word at 20'hFFFFF continues at 20'h00000.
- R9: `rsp_done` is high for exactly one clock, in the cycle right after the last bus cycle of the access.
- R10: A request is accepted only while `req_ready` is 1 (idle). A `req_valid` presented while busy starts no bus cycle, and the block returns to idle after its `rsp_done`.
- R11: `bus_be` is nonzero in every bus cycle and zero whenever `bus_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken at this edge |
| req_addr | input | 20 | Byte address of the access |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| bus_valid | output | 1 | A bus cycle is active this clock |
| bus_write | output | 1 | Bus cycle direction, 1 = write |
| bus_addr | output | 20 | Byte address of the bus cycle |
| bus_be | output | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| bus_wdata | output | 16 | Bus write data, with bytes on their lanes |
| bus_rdata | input | 16 | Bus read data, valid in the bus cycle |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid while `rsp_done` is high |

## Verification
If the sequencing state is wrong, the first bus cycle of the access shows it. An odd word issued as one cycle, or followed by a third, shows up as a wrong cycle count or a missing `rsp_done`, two or three clocks after acceptance. A lane or merge register that captures the wrong byte shows only in `rsp_rdata` at the completion pulse, or for writes in the memory contents read back later. The bench therefore compares each bus cycle and each completion against a model memory, and uses addresses at the top of the 20-bit range to expose a wrapping error in the second-cycle address.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_t;

  // A word whose address is odd straddles two bus words.
  function automatic logic needs_split(input logic addr_lsb, input logic is_word);
    return is_word & addr_lsb;
  endfunction

  // Lane enables for the first (or only) bus cycle of an access.
  function automatic logic [1:0] first_lanes(input logic addr_lsb, input logic is_word);
    logic [1:0] be;
    if (is_word && !addr_lsb) be = 2'b11;
    else if (addr_lsb)        be = 2'b10;
    else                      be = 2'b01;
    return be;
  endfunction

endpackage

// File: rtl/bls_ctrl.sv
module bls_ctrl #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              idle,
  output logic              in_first,
  output logic              in_second,
  output logic              in_done,
  output logic [ADDR_W-1:0] hold_addr,
  output logic              hold_word,
  output logic              hold_write,
  output logic [DATA_W-1:0] hold_wdata
);
  import bls_pkg::*;

  seq_state_t state_q, state_d;
  logic       accept;
  logic       split;

  assign accept = req_valid && (state_q == ST_IDLE);
  assign split  = needs_split(hold_addr[0], hold_word);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_FIRST;
      ST_FIRST:  state_d = split ? ST_SECOND : ST_DONE;
      ST_SECOND: state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      hold_addr  <= '0;
      hold_word  <= 1'b0;
      hold_write <= 1'b0;
      hold_wdata <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        hold_addr  <= req_addr;
        hold_word  <= req_word;
        hold_write <= req_write;
        hold_wdata <= req_wdata;
      end
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign in_first  = (state_q == ST_FIRST);
  assign in_second = (state_q == ST_SECOND);
  assign in_done   = (state_q == ST_DONE);
endmodule

// File: rtl/bls_steer.sv
module bls_steer #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              in_first,
  input  logic              in_second,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic              hold_word,
  input  logic              hold_write,
  input  logic [DATA_W-1:0] hold_wdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_be,
  output logic [DATA_W-1:0] bus_wdata
);
  import bls_pkg::*;

  logic [LANE_W-1:0] lo_byte, hi_byte, send_byte;
  logic              full_word;

  // Second-cycle address: natural wrap at 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  assign lo_byte   = hold_wdata[LANE_W-1:0];
  assign hi_byte   = hold_wdata[DATA_W-1:LANE_W];
  assign full_word = hold_word && !hold_addr[0];
  assign send_byte = in_second ? hi_byte : lo_byte;

  assign bus_valid = in_first | in_second;
  assign bus_write = bus_valid & hold_write;
  assign bus_addr  = in_second ? step_addr(hold_addr) : hold_addr;

  always_comb begin
    bus_be = 2'b00;
    if (in_first)       bus_be = first_lanes(hold_addr[0], hold_word);
    else if (in_second) bus_be = 2'b01;
  end

  // One byte is replicated on both lanes; only the enabled lane counts.
  assign bus_wdata = (in_first && full_word) ? hold_wdata : {send_byte, send_byte};
endmodule

// File: rtl/bls_merge.sv
module bls_merge #(
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_first,
  input  logic              in_second,
  input  logic              addr_lsb,
  input  logic              is_word,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [LANE_W-1:0] lo_q, hi_q;
  logic [LANE_W-1:0] lane0, lane1;

  assign lane0 = bus_rdata[LANE_W-1:0];
  assign lane1 = bus_rdata[DATA_W-1:LANE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (in_first) begin
      if (is_word && !addr_lsb) begin
        lo_q <= lane0;
        hi_q <= lane1;
      end else begin
        lo_q <= addr_lsb ? lane1 : lane0;
        hi_q <= '0;
      end
    end else if (in_second) begin
      hi_q <= lane0;
    end
  end

  assign rsp_rdata = {hi_q, lo_q};
endmodule

// File: rtl/byte_lane_seq.sv
module byte_lane_seq #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic              in_first, in_second, in_done, idle;
  logic [ADDR_W-1:0] hold_addr;
  logic              hold_word, hold_write;
  logic [DATA_W-1:0] hold_wdata;

  bls_ctrl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_word   (req_word),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .idle       (idle),
    .in_first   (in_first),
    .in_second  (in_second),
    .in_done    (in_done),
    .hold_addr  (hold_addr),
    .hold_word  (hold_word),
    .hold_write (hold_write),
    .hold_wdata (hold_wdata)
  );

  bls_steer #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_steer (
    .in_first   (in_first),
    .in_second  (in_second),
    .hold_addr  (hold_addr),
    .hold_word  (hold_word),
    .hold_write (hold_write),
    .hold_wdata (hold_wdata),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata)
  );

  bls_merge #(.LANE_W(LANE_W)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_first  (in_first),
    .in_second (in_second),
    .addr_lsb  (hold_addr[0]),
    .is_word   (hold_word),
    .bus_rdata (bus_rdata),
    .rsp_rdata (rsp_rdata)
  );

  assign req_ready = idle;
  assign rsp_done  = in_done;
endmodule

// File: rtl/byte_lane_seq_chk.sv
module byte_lane_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_be,
  input logic              rsp_done
);
  AST_BE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> bus_be == 2'b00);                                   // R11
  AST_BE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_be != 2'b00);                                    // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);                                           // R9
  AST_DONE_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(bus_valid) && !bus_valid);                      // R9
  AST_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && $past(bus_valid) |-> bus_be == 2'b01 &&
      bus_addr == ADDR_W'($past(bus_addr) + ADDR_W'(1)));              // R8
  AST_EVEN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_be == 2'b11 |-> !bus_addr[0]);                    // R4
  AST_LANE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_be != 2'b11 |-> bus_be == (bus_addr[0] ? 2'b10 : 2'b01)); // R3
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid && !rsp_done);                            // R10
endmodule

bind byte_lane_seq byte_lane_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_valid (bus_valid),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .rsp_done  (rsp_done)
);

// File: tb/test_byte_lane_seq.sv
module test_byte_lane_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        bus_valid, bus_write;
  logic [19:0] bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rsp_done;
  logic [15:0] rsp_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] mem [0:1023];

  always #(CLK_PERIOD / 2) clk = ~clk;

  byte_lane_seq i_byte_lane_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  // Memory model: zero-wait read, lane-enabled write at the clock edge.
  assign bus_rdata = mem[bus_addr[10:1]];
  always @(posedge clk) begin
    if (bus_valid && bus_write) begin
      if (bus_be[0]) mem[bus_addr[10:1]][7:0]  <= bus_wdata[7:0];
      if (bus_be[1]) mem[bus_addr[10:1]][15:8] <= bus_wdata[15:8];
    end
  end

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[0] ? mem[a[10:1]][15:8] : mem[a[10:1]][7:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [19:0] a, input logic w, input logic wr,
                         input logic [15:0] wd, input bit noise);
    logic [19:0] a1, nb_addr;
    logic [7:0]  exp_lo, exp_hi, old_nb;
    logic [19:0] c_addr [2];
    logic [1:0]  c_be [2];
    logic [15:0] c_wd [2];
    logic [15:0] rd;
    logic [1:0]  exp_be;
    logic [7:0]  lane_byte;
    int nb, done_k, done_cnt, exp_nb;
    bit be_bad, ready_after;
    string tag;
    a1 = a + 20'd1;
    nb_addr = {a[19:1], ~a[0]};
    exp_lo = mbyte(a);
    exp_hi = mbyte(a1);
    old_nb = mbyte(nb_addr);
    exp_nb = (w && a[0]) ? 2 : 1;
    tag = w ? (a[0] ? "R5" : "R4") : (a[0] ? "R3" : "R2");
    nb = 0; done_k = 0; done_cnt = 0; be_bad = 0; ready_after = 0; rd = '0;
    c_addr[0] = '0; c_addr[1] = '0; c_be[0] = '0; c_be[1] = '0; c_wd[0] = '0; c_wd[1] = '0;
    @(negedge clk);
    chk(req_ready, "R10", 32'(req_ready), 1);
    req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_wdata = wd;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (bus_valid) begin
        if (nb < 2) begin c_addr[nb] = bus_addr; c_be[nb] = bus_be; c_wd[nb] = bus_wdata; end
        nb++;
      end else if (bus_be != 2'b00) be_bad = 1;
      if (done_k != 0 && k == done_k + 1) ready_after = req_ready && !bus_valid;
      if (rsp_done) begin
        done_cnt++;
        if (done_k == 0) begin done_k = k; rd = rsp_rdata; end
      end
      if (noise && done_cnt == 0) begin
        req_valid = 1'b1; req_addr = a ^ 20'h000F0; req_word = ~w; req_write = 1'b1;
      end else req_valid = 1'b0;
    end
    chk(nb == exp_nb, tag, 32'(nb), 32'(exp_nb));
    chk(c_addr[0] == a, tag, 32'(c_addr[0]), 32'(a));
    exp_be = (w && !a[0]) ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
    chk(c_be[0] == exp_be, tag, 32'(c_be[0]), 32'(exp_be));
    chk(!be_bad, "R11", 32'(be_bad), 0);
    if (wr) begin
      if (exp_be == 2'b11) chk(c_wd[0] == wd, "R4", 32'(c_wd[0]), 32'(wd));
      else begin
        lane_byte = a[0] ? c_wd[0][15:8] : c_wd[0][7:0];
        chk(lane_byte == wd[7:0], tag, 32'(lane_byte), 32'(wd[7:0]));
      end
    end
    if (exp_nb == 2) begin
      chk(c_addr[1] == a1, "R8", 32'(c_addr[1]), 32'(a1));
      chk(c_be[1] == 2'b01, "R5", 32'(c_be[1]), 32'h1);
      if (wr) chk(c_wd[1][7:0] == wd[15:8], "R5", 32'(c_wd[1][7:0]), 32'(wd[15:8]));
    end
    chk(done_k == exp_nb + 1, "R9", 32'(done_k), 32'(exp_nb + 1));
    chk(done_cnt == 1, "R9", 32'(done_cnt), 1);
    chk(ready_after, "R10", 32'(ready_after), 1);
    if (!wr) begin
      if (w) chk(rd == {exp_hi, exp_lo}, a[0] ? "R6" : "R4", 32'(rd), 32'({exp_hi, exp_lo}));
      else   chk(rd == {8'h00, exp_lo}, "R7", 32'(rd), 32'({8'h00, exp_lo}));
    end else begin
      chk(mbyte(a) == wd[7:0], tag, 32'(mbyte(a)), 32'(wd[7:0]));
      if (w) chk(mbyte(a1) == wd[15:8], tag, 32'(mbyte(a1)), 32'(wd[15:8]));
      else   chk(mbyte(nb_addr) == old_nb, tag, 32'(mbyte(nb_addr)), 32'(old_nb));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 16'h1F3 + 16'h5A17);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1, "R1", 32'(req_ready), 1);
    chk(bus_valid === 1'b0 && bus_be === 2'b00, "R1", 32'({bus_valid, bus_be}), 0);
    chk(rsp_done === 1'b0, "R1", 32'(rsp_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed corners
    run_req(20'h00010, 1'b0, 1'b1, 16'h00A5, 0);   // R2 even byte write
    run_req(20'h00011, 1'b0, 1'b1, 16'h003C, 0);   // R3 odd byte write
    run_req(20'h00010, 1'b0, 1'b0, 16'h0000, 0);   // R7 even byte read
    run_req(20'h00011, 1'b0, 1'b0, 16'h0000, 0);   // R7 odd byte read
    run_req(20'h00020, 1'b1, 1'b1, 16'hBEEF, 0);   // R4 even word write
    run_req(20'h00020, 1'b1, 1'b0, 16'h0000, 0);   // R4 even word read
    run_req(20'h00031, 1'b1, 1'b1, 16'h1234, 0);   // R5 odd word write
    run_req(20'h00031, 1'b1, 1'b0, 16'h0000, 1);   // R6 odd word read, R10 noise
    run_req(20'hFFFFF, 1'b1, 1'b1, 16'hC3D2, 0);   // R8 wrap write
    run_req(20'hFFFFF, 1'b1, 1'b0, 16'h0000, 0);   // R8 wrap read
    run_req(20'h00000, 1'b0, 1'b0, 16'h0000, 0);   // R8 high byte landed at 0
    chk(rsp_rdata[7:0] == 8'hC3, "R8", 32'(rsp_rdata[7:0]), 32'hC3);
    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      run_req(20'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), ($urandom % 4) == 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule